// File: doc/BRIEF.md
# Decoupled Register Field Access Port

This block places one stored register field behind a pair of decoupled channels, one for reads and one for writes. Each channel has its own request handshake and its own response handshake, so a register-map decoder can issue an access and collect the result later. That suits fields that need more than one cycle to answer. The block accepts a request and parks the result in a one-entry response buffer. It then holds that result until the decoder takes it. Backpressure passes from response to request through a single combinational term.

The combinational dependencies are kept deliberately narrow. A request ready depends only on the channel's own response ready and its buffer state. Response valid and read data come straight from flops. As a result, no loop can form through the decoder. A write changes the field in the cycle after it is accepted. That is never later than the cycle after its response handshake. A read returns the field value as it stood in the cycle of acceptance.

Top module: `regfield_port`

## Requirements
- R1: In the first cycle after reset, both response valids are low, both request readys are high, and the field output equals the parameter `RESET_VAL`.
- R2: The read request ready is high exactly when the read response buffer is empty or the read response ready is high, whatever the read request valid.
- R3: A read accepted in cycle N (request valid and ready both high) raises the read response valid in cycle N+1, with read data equal to the field value in cycle N, sampled before any write accepted in cycle N takes effect.
- R4: While a response valid is high and its response ready is low, the response valid stays high and the read data does not change.
- R5: A write accepted in cycle N sets the field output to the write data in cycle N+1 and raises the write response valid in cycle N+1.
- R6: Write data offered while the write request ready is low, or while the write request valid is low, leaves the field output unchanged.
- R7: The write request ready is high exactly when the write response buffer is empty or the write response ready is high, independent of the write request valid.
- R8: With both response readys held high, each channel accepts one request in every cycle its request valid is high.
- R9: A response valid falls in the cycle after its response handshake unless a new request on that channel was accepted in the handshake cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_rsp_valid | output | 1 | Read result held in buffer |
| rd_rsp_ready | input | 1 | Decoder takes the read result |
| rd_data | output | WIDTH | Read result, meaningful while rd_rsp_valid is high |
| wr_req_valid | input | 1 | Write request offered |
| wr_req_ready | output | 1 | Write request can be taken |
| wr_req_data | input | WIDTH | Value to store |
| wr_rsp_valid | output | 1 | Write completion held in buffer |
| wr_rsp_ready | input | 1 | Decoder takes the write completion |
| field_q | output | WIDTH | Current stored field value |

## Verification
The hardest case to reach is a read and a write that are accepted in the same cycle while both response buffers are full and draining. Only in that case do the pass-through ready term and the pre-write read sampling matter together. The bench creates it by running long random phases with high request rates and medium response-ready rates, so that buffers refill in the same cycle they drain. A behavioural queue model is compared against the ports on every cycle, which exposes any mismatch in ordering or readiness. Separate phases hold the response readys low to cover stalls and high to cover full throughput.

// File: rtl/regfield_port.sv
module regfield_port #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_req_valid,
  output logic             rd_req_ready,
  output logic             rd_rsp_valid,
  input  logic             rd_rsp_ready,
  output logic [WIDTH-1:0] rd_data,
  input  logic             wr_req_valid,
  output logic             wr_req_ready,
  input  logic [WIDTH-1:0] wr_req_data,
  output logic             wr_rsp_valid,
  input  logic             wr_rsp_ready,
  output logic [WIDTH-1:0] field_q
);

  logic             rd_full, wr_full;
  logic [WIDTH-1:0] rd_buf, store;
  logic             rd_take, wr_take;

  assign rd_req_ready = !rd_full || rd_rsp_ready;
  assign wr_req_ready = !wr_full || wr_rsp_ready;
  assign rd_take      = rd_req_valid && rd_req_ready;
  assign wr_take      = wr_req_valid && wr_req_ready;
  assign rd_rsp_valid = rd_full;
  assign wr_rsp_valid = wr_full;
  assign rd_data      = rd_buf;
  assign field_q      = store;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_full <= 1'b0;
      rd_buf  <= '0;
    end else if (rd_take) begin
      rd_full <= 1'b1;
      rd_buf  <= store;
    end else if (rd_rsp_ready) begin
      rd_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_full <= 1'b0;
      store   <= RESET_VAL;
    end else if (wr_take) begin
      wr_full <= 1'b1;
      store   <= wr_req_data;
    end else if (wr_rsp_ready) begin
      wr_full <= 1'b0;
    end
  end

  AST_RD_RESULT: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && rd_req_ready |=> rd_rsp_valid && rd_data == $past(field_q)); // R3
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_rsp_valid && !rd_rsp_ready |=> rd_rsp_valid && $stable(rd_data)); // R4
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
    wr_rsp_valid && !wr_rsp_ready |=> wr_rsp_valid); // R4
  AST_WR_EFFECT: assert property (@(posedge clk) disable iff (rst)
    wr_req_valid && wr_req_ready |=> wr_rsp_valid && field_q == $past(wr_req_data)); // R5
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(wr_req_valid && wr_req_ready) |=> $stable(field_q)); // R6
  AST_RD_DRAIN: assert property (@(posedge clk) disable iff (rst)
    rd_rsp_valid && rd_rsp_ready && !rd_req_valid |=> !rd_rsp_valid); // R9
  AST_WR_DRAIN: assert property (@(posedge clk) disable iff (rst)
    wr_rsp_valid && wr_rsp_ready && !wr_req_valid |=> !wr_rsp_valid); // R9

endmodule

// File: tb/tb_regfield_port.sv
module tb_regfield_port;
  localparam int W = 32;
  localparam logic [W-1:0] RV = 32'hA5C3_0F18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req_valid = 0, rd_rsp_ready = 0, wr_req_valid = 0, wr_rsp_ready = 0;
  logic [W-1:0] wr_req_data = '0;
  logic rd_req_ready, rd_rsp_valid, wr_req_ready, wr_rsp_valid;
  logic [W-1:0] rd_data, field_q;

  int checks = 0, errors = 0;
  bit m_rd_full, m_wr_full;
  logic [W-1:0] m_rd_buf, m_field;

  always #5 clk = ~clk;

  regfield_port #(.WIDTH(W), .RESET_VAL(RV)) dut (
    .clk(clk), .rst(rst),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready), .rd_data(rd_data),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_data(wr_req_data),
    .wr_rsp_valid(wr_rsp_valid), .wr_rsp_ready(wr_rsp_ready), .field_q(field_q));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk("R2 rd_req_ready", W'(rd_req_ready), W'(!m_rd_full || rd_rsp_ready));
    chk("R7 wr_req_ready", W'(wr_req_ready), W'(!m_wr_full || wr_rsp_ready));
    chk("R9 rd_rsp_valid", W'(rd_rsp_valid), W'(m_rd_full));
    chk("R9 wr_rsp_valid", W'(wr_rsp_valid), W'(m_wr_full));
    if (m_rd_full) chk("R3 R4 rd_data", rd_data, m_rd_buf);
    chk("R5 R6 field_q", field_q, m_field);
  endtask

  task automatic step();
    bit ra, wa;
    ra = rd_req_valid && (!m_rd_full || rd_rsp_ready);
    wa = wr_req_valid && (!m_wr_full || wr_rsp_ready);
    @(posedge clk);
    if (ra) begin m_rd_full = 1; m_rd_buf = m_field; end
    else if (rd_rsp_ready) m_rd_full = 0;
    if (wa) begin m_wr_full = 1; m_field = wr_req_data; end
    else if (wr_rsp_ready) m_wr_full = 0;
  endtask

  task automatic phase(input int n, input int p_rv, input int p_rr, input int p_wv, input int p_wr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_req_valid = ($urandom % 100) < p_rv;
      rd_rsp_ready = ($urandom % 100) < p_rr;
      wr_req_valid = ($urandom % 100) < p_wv;
      wr_rsp_ready = ($urandom % 100) < p_wr;
      wr_req_data  = $urandom;
      #1;
      compare();
      if (p_rr == 100 && p_wr == 100) begin
        chk("R8 rd accept", W'(rd_req_ready), W'(1));
        chk("R8 wr accept", W'(wr_req_ready), W'(1));
      end
      step();
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    m_rd_full = 0; m_wr_full = 0; m_rd_buf = '0; m_field = RV;
    #1;
    chk("R1 rd_rsp_valid", W'(rd_rsp_valid), W'(0));
    chk("R1 wr_rsp_valid", W'(wr_rsp_valid), W'(0));
    chk("R1 rd_req_ready", W'(rd_req_ready), W'(1));
    chk("R1 wr_req_ready", W'(wr_req_ready), W'(1));
    chk("R1 field_q", field_q, RV);
    step();
    phase(200, 100, 100, 100, 100);
    phase(300, 80, 0, 80, 0);
    phase(2000, 90, 50, 90, 50);
    phase(1000, 20, 70, 30, 70);
    phase(2000, 60, 30, 70, 40);
    phase(300, 0, 100, 0, 100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule